// File: doc/BRIEF.md
# Event-Synchronized Complementary Gate Driver

This block produces two complementary gate drives for a half-bridge leg: one for the active switch and one for the synchronous switch. It has no period register. An external zero-crossing detect input restarts a free-running up-counter, so each switching period lasts from one detected edge to the next. Two compare thresholds place the edges within the period. A rising-edge dead time on the active drive and a falling-edge dead time on the synchronous drive keep the two switches from conducting together.

The four timing settings are written through a valid/ready configuration port into a shadow set, and a pending flag is raised. On the next zero-crossing event all four settings move into the active set in the same clock edge that restarts the counter. If the shadow set breaks the ordering rules, the block does not load it. It keeps the previous active set and raises a sticky error flag. If no zero-crossing arrives, the counter stops at its maximum value and both drives are held low until the next event. The configuration port has no back-pressure: `cfg_ready` is low only while reset is applied and stays high from the first clock edge after reset. A beat transfers on every clock edge where `cfg_valid` and `cfg_ready` are both high, and a later beat overwrites an earlier one that has not been loaded.

Top module: `evsync_pwm`

## Requirements
- R1: While reset is applied and after it is released, both gate drives are low and `cfg_pending` and `cfg_err` are low. `cfg_ready` is high from the first clock edge after reset. The reset active set is compare A = 0, compare B = all ones and both dead times = 0, so neither drive turns on before the first configuration is loaded.
- R2: `zcd_in` passes through a two-flop synchronizer and its rising edge makes a one-clock sync pulse. The counter reads zero from the third rising clock edge after `zcd_in` rises and then counts up by one per clock.
- R3: The active drive is requested while the count is below compare A. Its rising edge is delayed by the rising dead time in clocks. Counting n from the clock edge at which `zcd_in` is driven high, the drive is high for n from 4 + rising dead time to 3 + compare A.
- R4: The synchronous drive is requested from the count equal to compare B until the next sync event. It first reads high at n = 4 + compare B.
- R5: When a new period starts, the synchronous drive stays high for the falling dead time in clocks. Its last high sample is at n = 3 + falling dead time, and it reads low at n = 4 + falling dead time.
- R6: The two gate drives are never high in the same cycle.
- R7: A configuration beat stores compare A, compare B and both dead times in the shadow set. `cfg_pending` is high from the next cycle. The beat does not change the drives of the period that is running.
- R8: On a sync event with `cfg_pending` high, all four shadow values become active at the edge that zeroes the counter, and `cfg_pending` clears. The active set does not change at any other time.
- R9: A pending set with compare B not greater than compare A, or with rising dead time not greater than falling dead time, is discarded at the sync event. The previous active set stays in use, `cfg_pending` clears, and `cfg_err` goes high and stays high until reset. Later valid sets still load.
- R10: Without a sync event the counter stops at 2^CNT_W - 1. From n = 4 + (2^CNT_W - 1) both drives read low and stay low until the next sync event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zcd_in | input | 1 | Asynchronous zero-crossing detect |
| cfg_valid | input | 1 | Configuration beat valid |
| cfg_ready | output | 1 | Configuration beat accepted |
| cfg_cmpa | input | CNT_W | Active-drive turn-off count |
| cfg_cmpb | input | CNT_W | Synchronous-drive turn-on count |
| cfg_red | input | DLY_W | Rising dead time of the active drive, clocks |
| cfg_fed | input | DLY_W | Falling dead time of the synchronous drive, clocks |
| gate_act | output | 1 | Active switch drive |
| gate_syn | output | 1 | Synchronous switch drive |
| cfg_pending | output | 1 | Shadow set waiting for a sync event |
| cfg_err | output | 1 | Sticky flag: a rejected shadow set |

## Verification
The main function is tried with several compare and dead-time sets over back-to-back periods of different lengths. Measuring where each edge falls tells a missing dead time apart from an off-by-one in the synchronizer latency or the compare. Sets written in the middle of a period show whether the running period keeps its old edges and whether the next period switches all four values at once. The falling dead time at the start of the first new period shows whether the new set is used from the first edge. Two invalid sets, one breaking each ordering rule, followed by a valid one, separate rejection from stickiness. A run with no zero-crossing, followed by a restart, covers the saturating timeout.

// File: rtl/evsync_pwm_pkg.sv
package evsync_pwm_pkg;
  typedef enum logic {
    EDGE_DELAY_RISE = 1'b0,
    EDGE_DELAY_FALL = 1'b1
  } edge_delay_e;
endpackage

// File: rtl/evsync_edge.sv
module evsync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= async_in;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else last_q <= chain[STAGES-1];
  end

  assign rise_pulse = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/evsync_shadow.sv
module evsync_shadow #(
  parameter int CNT_W = 12,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_cmpa,
  input  logic [CNT_W-1:0] wr_cmpb,
  input  logic [DLY_W-1:0] wr_red,
  input  logic [DLY_W-1:0] wr_fed,
  input  logic             load,
  output logic [CNT_W-1:0] act_cmpa,
  output logic [CNT_W-1:0] act_cmpb,
  output logic [DLY_W-1:0] act_red,
  output logic [DLY_W-1:0] act_fed,
  output logic             pending,
  output logic             err
);
  logic [CNT_W-1:0] sh_cmpa, sh_cmpb;
  logic [DLY_W-1:0] sh_red, sh_fed;
  logic             sh_ok;

  assign sh_ok = (sh_cmpb > sh_cmpa) && (sh_red > sh_fed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_cmpa  <= '0;
      sh_cmpb  <= '0;
      sh_red   <= '0;
      sh_fed   <= '0;
      act_cmpa <= '0;
      act_cmpb <= '1;
      act_red  <= '0;
      act_fed  <= '0;
      pending  <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (wr) begin
        sh_cmpa <= wr_cmpa;
        sh_cmpb <= wr_cmpb;
        sh_red  <= wr_red;
        sh_fed  <= wr_fed;
      end
      if (load && pending) begin
        if (sh_ok) begin
          act_cmpa <= sh_cmpa;
          act_cmpb <= sh_cmpb;
          act_red  <= sh_red;
          act_fed  <= sh_fed;
        end else begin
          err <= 1'b1;
        end
      end
      if (wr) pending <= 1'b1;
      else if (load) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/evsync_counter.sv
module evsync_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count,
  output logic             enable
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (restart) begin
      count   <= '0;
      running <= 1'b1;
    end else if (count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end

  assign enable = running && (count != CNT_MAX);
endmodule

// File: rtl/evsync_deadband.sv
module evsync_deadband #(
  parameter int                           DLY_W = 8,
  parameter evsync_pwm_pkg::edge_delay_e  EDGE  = evsync_pwm_pkg::EDGE_DELAY_RISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             force_low,
  input  logic [DLY_W-1:0] dly,
  output logic             dout
);
  logic [DLY_W-1:0] wait_q;

  generate
    if (EDGE == evsync_pwm_pkg::EDGE_DELAY_RISE) begin : g_rise
      always_ff @(posedge clk) begin
        if (!rst_n || force_low || !din) begin
          dout   <= 1'b0;
          wait_q <= '0;
        end else if (wait_q == dly) begin
          dout <= 1'b1;
        end else begin
          wait_q <= wait_q + 1'b1;
        end
      end
    end else begin : g_fall
      always_ff @(posedge clk) begin
        if (!rst_n || force_low) begin
          dout   <= 1'b0;
          wait_q <= '0;
        end else if (din) begin
          dout   <= 1'b1;
          wait_q <= '0;
        end else if (dout) begin
          if (wait_q == dly) dout <= 1'b0;
          else wait_q <= wait_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/evsync_pwm.sv
module evsync_pwm #(
  parameter int CNT_W = 12,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zcd_in,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [CNT_W-1:0] cfg_cmpa,
  input  logic [CNT_W-1:0] cfg_cmpb,
  input  logic [DLY_W-1:0] cfg_red,
  input  logic [DLY_W-1:0] cfg_fed,
  output logic             gate_act,
  output logic             gate_syn,
  output logic             cfg_pending,
  output logic             cfg_err
);
  logic             sync_pulse;
  logic             cfg_fire;
  logic [CNT_W-1:0] cnt;
  logic             cnt_en;
  logic [CNT_W-1:0] a_cmpa, a_cmpb;
  logic [DLY_W-1:0] a_red, a_fed;
  logic             req_act, req_syn;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_ready <= 1'b0;
    else cfg_ready <= 1'b1;
  end

  assign cfg_fire = cfg_valid && cfg_ready;

  evsync_edge #(.STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .async_in(zcd_in), .rise_pulse(sync_pulse)
  );

  evsync_shadow #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr(cfg_fire),
    .wr_cmpa(cfg_cmpa), .wr_cmpb(cfg_cmpb), .wr_red(cfg_red), .wr_fed(cfg_fed),
    .load(sync_pulse),
    .act_cmpa(a_cmpa), .act_cmpb(a_cmpb), .act_red(a_red), .act_fed(a_fed),
    .pending(cfg_pending), .err(cfg_err)
  );

  evsync_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(sync_pulse), .count(cnt), .enable(cnt_en)
  );

  // action qualifier: set/clear events expressed as count windows
  assign req_act = cnt_en && (cnt < a_cmpa);
  assign req_syn = cnt_en && (cnt >= a_cmpb);

  evsync_deadband #(.DLY_W(DLY_W), .EDGE(evsync_pwm_pkg::EDGE_DELAY_RISE)) u_db_act (
    .clk(clk), .rst_n(rst_n), .din(req_act), .force_low(!cnt_en),
    .dly(a_red), .dout(gate_act)
  );

  evsync_deadband #(.DLY_W(DLY_W), .EDGE(evsync_pwm_pkg::EDGE_DELAY_FALL)) u_db_syn (
    .clk(clk), .rst_n(rst_n), .din(req_syn), .force_low(!cnt_en),
    .dly(a_fed), .dout(gate_syn)
  );
endmodule

// File: rtl/evsync_pwm_chk.sv
module evsync_pwm_chk #(
  parameter int CNT_W = 12,
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync,
  input logic             wr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_cmpa,
  input logic [CNT_W-1:0] act_cmpb,
  input logic [DLY_W-1:0] act_red,
  input logic [DLY_W-1:0] act_fed,
  input logic             gate_act,
  input logic             gate_syn,
  input logic             pending,
  input logic             err
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n) !(gate_act && gate_syn)); // R6
  AST_SYNC_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rst_n) sync |=> (cnt == '0)); // R2
  AST_WRITE_PENDS: assert property (@(posedge clk) disable iff (!rst_n) wr |=> pending); // R7
  AST_PENDING_RETIRED: assert property (@(posedge clk) disable iff (!rst_n) (sync && !wr) |=> !pending); // R8
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> ($stable(act_cmpa) && $stable(act_cmpb) && $stable(act_red) && $stable(act_fed))); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R9
  AST_ACTIVE_ORDERED: assert property (@(posedge clk) disable iff (!rst_n) act_cmpb > act_cmpa); // R9
  AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_TOP) |=> (!gate_act && !gate_syn)); // R10
endmodule

bind evsync_pwm evsync_pwm_chk #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync(sync_pulse), .wr(cfg_fire), .cnt(cnt),
  .act_cmpa(a_cmpa), .act_cmpb(a_cmpb), .act_red(a_red), .act_fed(a_fed),
  .gate_act(gate_act), .gate_syn(gate_syn), .pending(cfg_pending), .err(cfg_err)
);

// File: tb/evsync_pwm_test.sv
module evsync_pwm_test;
  localparam int CW = 10;
  localparam int DW = 8;
  localparam int TOP = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, zcd = 1'b0, cfg_valid = 1'b0, cfg_ready;
  logic [CW-1:0] cfg_cmpa = '0, cfg_cmpb = '0;
  logic [DW-1:0] cfg_red = '0, cfg_fed = '0;
  logic gate_act, gate_syn, cfg_pending, cfg_err;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int wr_at = -1, wa, wb, wr_, wf;

  always #10 clk = ~clk;

  evsync_pwm #(.CNT_W(CW), .DLY_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .zcd_in(zcd), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_cmpa(cfg_cmpa), .cfg_cmpb(cfg_cmpb), .cfg_red(cfg_red), .cfg_fed(cfg_fed),
    .gate_act(gate_act), .gate_syn(gate_syn), .cfg_pending(cfg_pending), .cfg_err(cfg_err)
  );

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive_cfg(int a, int b, int r, int f);
    cfg_valid = 1'b1;
    cfg_cmpa = a[CW-1:0]; cfg_cmpb = b[CW-1:0];
    cfg_red = r[DW-1:0]; cfg_fed = f[DW-1:0];
  endtask

  task automatic reset_check();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 act in reset", gate_act, 0);
    check("R1 syn in reset", gate_syn, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready", cfg_ready, 1);
    check("R1 pending", cfg_pending, 0);
    check("R1 err", cfg_err, 0);
    check("R1 act idle", gate_act, 0);
    check("R1 syn idle", gate_syn, 0);
  endtask

  task automatic write_now(int a, int b, int r, int f);
    drive_cfg(a, b, r, f);
    @(negedge clk);
    cfg_valid = 1'b0;
    check("R7 pending after write", cfg_pending, 1);
  endtask

  // One period: zcd rises at n = 0; the next zcd is raised by the next call at n = L.
  task automatic run_period(int L, int a, int b, int r, int f, bit prev_syn, bit exp_pend, bit exp_err);
    int act_first = -1, act_cnt = 0, syn_rise = -1, syn_fall = -1;
    logic syn_prev = gate_syn;
    zcd = 1'b1;
    for (int n = 1; n <= L; n++) begin
      @(negedge clk);
      if (n == 2) zcd = 1'b0;
      if (n == wr_at) drive_cfg(wa, wb, wr_, wf);
      if (n == wr_at + 1) begin
        cfg_valid = 1'b0;
        check("R7 pending after mid-period write", cfg_pending, 1);
      end
      if (gate_act) begin
        act_cnt++;
        if (act_first < 0) act_first = n;
      end
      if (gate_syn && !syn_prev && syn_rise < 0) syn_rise = n;
      if (!gate_syn && syn_fall < 0) syn_fall = n;
      syn_prev = gate_syn;
    end
    wr_at = -1;
    if (a > r) begin
      check("R3 active rise position", act_first, 4 + r);
      check("R3 active width", act_cnt, a - r);
    end
    check("R4 sync rise position", syn_rise, 4 + b);
    if (prev_syn) check("R5 sync fall after dead time", syn_fall, 4 + f);
    check("R8 pending at period end", cfg_pending, exp_pend);
    check("R9 error flag", cfg_err, exp_err);
  endtask

  task automatic timeout_run();
    int bad = 0;
    zcd = 1'b1;
    for (int n = 1; n <= 4 + TOP + 20; n++) begin
      @(negedge clk);
      if (n == 2) zcd = 1'b0;
      if (n == 3 + TOP) check("R10 sync high before saturation", gate_syn, 1);
      if (n == 4 + TOP) check("R10 sync low at saturation", gate_syn, 0);
      if (n >= 4 + TOP && (gate_act || gate_syn)) bad++;
    end
    check("R10 drives stay low after timeout", bad, 0);
  endtask

  initial begin
    reset_check();
    write_now(20, 40, 5, 2);
    run_period(60, 20, 40, 5, 2, 0, 0, 0);
    run_period(60, 20, 40, 5, 2, 1, 0, 0);
    wr_at = 10; wa = 10; wb = 30; wr_ = 3; wf = 1;
    run_period(60, 20, 40, 5, 2, 1, 1, 0);
    run_period(60, 10, 30, 3, 1, 1, 0, 0);
    wr_at = 10; wa = 30; wb = 30; wr_ = 3; wf = 1;
    run_period(60, 10, 30, 3, 1, 1, 1, 0);
    run_period(60, 10, 30, 3, 1, 1, 0, 1);
    wr_at = 10; wa = 5; wb = 50; wr_ = 2; wf = 2;
    run_period(60, 10, 30, 3, 1, 1, 1, 1);
    run_period(60, 10, 30, 3, 1, 1, 0, 1);
    wr_at = 10; wa = 50; wb = 70; wr_ = 8; wf = 4;
    run_period(90, 10, 30, 3, 1, 1, 1, 1);
    run_period(90, 50, 70, 8, 4, 1, 0, 1);
    timeout_run();
    run_period(90, 50, 70, 8, 4, 0, 0, 1);
    zcd = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 drives low right after restart edge", gate_act, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule